// File: doc/BRIEF.md
# Minimal Accumulator Processor Core

This block is a small 16-bit processor built around a single accumulator. It fetches one-word instructions from a 4096-word memory and runs each one through a short multi-cycle sequence. It holds three architectural registers: the accumulator (ACC), a 12-bit program counter (PC) and the instruction register (IR). Every calculation reads ACC and writes its result back to ACC.

Each instruction word splits into a 4-bit opcode and a 12-bit direct address. The core reaches the outside world through one memory port, which carries an address, write data, read data, a read strobe and a write strobe. Reads are synchronous: data returns one cycle after the strobe. The opcode set covers the following:

- load and store;
- wrapping add and subtract;
- an unconditional jump;
- a jump on a non-negative accumulator;
- a jump on a non-zero accumulator;
- stop.

A build-time parameter makes the sign-test jump fire only on a strictly positive accumulator. A halted output reports when the core has stopped.

Top module: `acp_core`

## Requirements
- R1: While `rst_n` is low (asserted asynchronously), and after its synchronized release: ACC and PC are zero, `halted` is low, no write strobe is issued, and the first fetch reads address 0.
- R2: An instruction word carries its opcode in bits [15:12] and its operand address S in bits [11:0]. Each fetch reads mem[PC] and then advances PC by one. PC wraps from 4095 to 0.
- R3: Opcode 0000 loads mem[S] into ACC. Opcode 0001 issues exactly one write strobe with address S and data ACC, and leaves ACC unchanged.
- R4: Opcode 0010 sets ACC to ACC + mem[S], and opcode 0011 sets ACC to ACC - mem[S]. Both wrap modulo 2^16.
- R5: Opcode 0100 always continues execution at address S.
- R6: With `STRICT_POS` = 0, opcode 0101 jumps to S exactly when ACC bit 15 is 0.
- R7: Opcode 0110 jumps to S exactly when ACC is non-zero.
- R8: Opcode 0111 ignores its operand bits and raises `halted`. `halted` then stays high, and neither strobe is asserted again until reset.
- R9: Opcodes 1000 through 1111 act as stop. They write nothing and halt the core.
- R10: With `STRICT_POS` = 1, opcode 0101 jumps only when ACC bit 15 is 0 and ACC is non-zero.
- R11: The read and write strobes are never asserted in the same cycle. Read data is taken one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronized release |
| mem_addr | output | 12 | Memory word address |
| mem_rd | output | 1 | Read strobe; data is expected on `mem_rdata` in the next cycle |
| mem_wr | output | 1 | Write strobe for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 16 | Store data (accumulator value) |
| mem_rdata | input | 16 | Synchronous read data |
| halted | output | 1 | High once a stop or unassigned opcode has executed |

## Verification
A wrong program counter shows on `mem_addr` at the very next fetch, three or four cycles after the faulty instruction. It then quickly diverts the program into the wrong stores or into an early halt. A wrong accumulator is visible only when a later store places it on `mem_wdata`, or when it steers a conditional jump the wrong way. For that reason the programs store their intermediate values, and they encode every branch outcome as a distinct stored marker. A sequencer that stops early or late shows at once as a wrong `halted` level, or as strobes that continue after the stop.

// File: rtl/acp_pkg.sv
package acp_pkg;

  localparam int unsigned OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h0;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'h1;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'h2;
  localparam logic [OPC_W-1:0] OPC_SUB   = 4'h3;
  localparam logic [OPC_W-1:0] OPC_JMP   = 4'h4;
  localparam logic [OPC_W-1:0] OPC_JPOS  = 4'h5;
  localparam logic [OPC_W-1:0] OPC_JNZ   = 4'h6;
  localparam logic [OPC_W-1:0] OPC_STOP  = 4'h7;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_EXEC   = 3'd2,
    ST_WBACK  = 3'd3,
    ST_HALT   = 3'd4
  } acp_state_e;

  typedef struct packed {
    logic mem_rd;
    logic mem_wr;
    logic addr_pc;
    logic ir_en;
    logic pc_inc;
    logic pc_jump;
    logic acc_en;
  } acp_ctl_t;

endpackage

// File: rtl/acp_rst_sync.sv
module acp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= STAGES'({chain_q, 1'b1});
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/acp_alu.sv
module acp_alu
  import acp_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [OPC_W-1:0]  opc,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] mdata,
  output logic [DATA_W-1:0] result
);

  always_comb begin
    case (opc)
      OPC_LOAD: result = mdata;
      OPC_ADD:  result = acc + mdata;
      OPC_SUB:  result = acc - mdata;
      default:  result = acc;
    endcase
  end

endmodule

// File: rtl/acp_branch.sv
module acp_branch
  import acp_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter bit          STRICT_POS = 1'b0
) (
  input  logic [OPC_W-1:0]  opc,
  input  logic [DATA_W-1:0] acc,
  output logic              take
);

  logic acc_pos;
  logic acc_nz;

  assign acc_nz = |acc;

  generate
    if (STRICT_POS) begin : g_strict
      assign acc_pos = !acc[DATA_W-1] && acc_nz;
    end else begin : g_nonneg
      assign acc_pos = !acc[DATA_W-1];
    end
  endgenerate

  always_comb begin
    case (opc)
      OPC_JMP:  take = 1'b1;
      OPC_JPOS: take = acc_pos;
      OPC_JNZ:  take = acc_nz;
      default:  take = 1'b0;
    endcase
  end

endmodule

// File: rtl/acp_seq.sv
module acp_seq
  import acp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opc,
  input  logic             take,
  output acp_ctl_t         ctl,
  output logic             halted
);

  acp_state_e state_q;
  acp_state_e state_d;

  always_comb begin
    state_d = state_q;
    ctl     = '0;
    case (state_q)
      ST_FETCH: begin
        ctl.mem_rd  = 1'b1;
        ctl.addr_pc = 1'b1;
        state_d     = ST_DECODE;
      end
      ST_DECODE: begin
        ctl.ir_en  = 1'b1;
        ctl.pc_inc = 1'b1;
        state_d    = ST_EXEC;
      end
      ST_EXEC: begin
        case (opc)
          OPC_LOAD, OPC_ADD, OPC_SUB: begin
            ctl.mem_rd = 1'b1;
            state_d    = ST_WBACK;
          end
          OPC_STORE: begin
            ctl.mem_wr = 1'b1;
            state_d    = ST_FETCH;
          end
          OPC_JMP, OPC_JPOS, OPC_JNZ: begin
            ctl.pc_jump = take;
            state_d     = ST_FETCH;
          end
          default: begin
            state_d = ST_HALT;
          end
        endcase
      end
      ST_WBACK: begin
        ctl.acc_en = 1'b1;
        state_d    = ST_FETCH;
      end
      default: begin
        state_d = ST_HALT;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
    end else begin
      state_q <= state_d;
    end
  end

  assign halted = (state_q == ST_HALT);

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R8
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !(ctl.mem_rd || ctl.mem_wr)); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl.mem_rd && ctl.mem_wr)); // R11
  AST_RD_THEN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.mem_rd && ctl.addr_pc) |=> ctl.ir_en); // R11

endmodule

// File: rtl/acp_core.sv
module acp_core
  import acp_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned ADDR_W      = 12,
  parameter bit          STRICT_POS  = 1'b0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted
);

  localparam int unsigned OPC_LSB = ADDR_W;

  logic              core_rst_n;
  acp_ctl_t          ctl;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] acc_d;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_d;
  logic [DATA_W-1:0] ir_q;
  logic [OPC_W-1:0]  opc;
  logic [ADDR_W-1:0] operand;
  logic              take;

  assign opc     = ir_q[OPC_LSB +: OPC_W];
  assign operand = ir_q[ADDR_W-1:0];

  acp_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(core_rst_n)
  );

  acp_seq u_seq (
    .clk   (clk),
    .rst_n (core_rst_n),
    .opc   (opc),
    .take  (take),
    .ctl   (ctl),
    .halted(halted)
  );

  acp_branch #(
    .DATA_W    (DATA_W),
    .STRICT_POS(STRICT_POS)
  ) u_branch (
    .opc (opc),
    .acc (acc_q),
    .take(take)
  );

  acp_alu #(
    .DATA_W(DATA_W)
  ) u_alu (
    .opc   (opc),
    .acc   (acc_q),
    .mdata (mem_rdata),
    .result(acc_d)
  );

  always_comb begin
    pc_d = pc_q;
    if (ctl.pc_jump) begin
      pc_d = operand;
    end else if (ctl.pc_inc) begin
      pc_d = pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      pc_q <= '0;
    end else if (ctl.pc_jump || ctl.pc_inc) begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      ir_q <= '0;
    end else if (ctl.ir_en) begin
      ir_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      acc_q <= '0;
    end else if (ctl.acc_en) begin
      acc_q <= acc_d;
    end
  end

  assign mem_addr  = ctl.addr_pc ? pc_q : operand;
  assign mem_rd    = ctl.mem_rd;
  assign mem_wr    = ctl.mem_wr;
  assign mem_wdata = acc_q;

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!core_rst_n)
    ctl.pc_inc |=> pc_q == ADDR_W'($past(pc_q) + 1'b1)); // R2
  AST_STORE_KEEPS_ACC: assert property (@(posedge clk) disable iff (!core_rst_n)
    mem_wr |=> $stable(acc_q)); // R3
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!core_rst_n)
    ctl.pc_jump |=> pc_q == $past(ir_q[ADDR_W-1:0])); // R5
  AST_JPOS_SIGN: assert property (@(posedge clk) disable iff (!core_rst_n)
    (ctl.pc_jump && opc == OPC_JPOS) |-> !acc_q[DATA_W-1]); // R6
  AST_JNZ_VALUE: assert property (@(posedge clk) disable iff (!core_rst_n)
    (ctl.pc_jump && opc == OPC_JNZ) |-> (acc_q != '0)); // R7
  AST_STRICT_ZERO: assert property (@(posedge clk) disable iff (!core_rst_n)
    (STRICT_POS && ctl.pc_jump && opc == OPC_JPOS) |-> (acc_q != '0)); // R10

endmodule

// File: tb/acp_core_bench.sv
module acp_core_bench_mem (
  input  logic        clk,
  input  logic        rd,
  input  logic        wr,
  input  logic [11:0] addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        ld_en,
  input  logic [11:0] ld_addr,
  input  logic [15:0] ld_data
);
  logic [15:0] mem [4096];

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (wr) mem[addr] <= wdata;
    if (rd) rdata <= mem[addr];
  end
endmodule

module acp_core_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [11:0] ld_addr = '0;
  logic [15:0] ld_data = '0;

  logic [11:0] addr_a, addr_s;
  logic        rd_a, wr_a, rd_s, wr_s, halted_a, halted_s;
  logic [15:0] wdata_a, wdata_s, rdata_a, rdata_s;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int leak_cnt = 0;
  int both_cnt = 0;
  int wr_cnt_a = 0;

  always #10 clk = ~clk;

  acp_core u_acp_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(addr_a), .mem_rd(rd_a), .mem_wr(wr_a),
    .mem_wdata(wdata_a), .mem_rdata(rdata_a), .halted(halted_a)
  );

  acp_core #(.STRICT_POS(1'b1)) u_acp_core_strict (
    .clk(clk), .rst_n(rst_n), .mem_addr(addr_s), .mem_rd(rd_s), .mem_wr(wr_s),
    .mem_wdata(wdata_s), .mem_rdata(rdata_s), .halted(halted_s)
  );

  acp_core_bench_mem u_mem_a (
    .clk(clk), .rd(rd_a), .wr(wr_a), .addr(addr_a), .wdata(wdata_a), .rdata(rdata_a),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  acp_core_bench_mem u_mem_s (
    .clk(clk), .rd(rd_s), .wr(wr_s), .addr(addr_s), .wdata(wdata_s), .rdata(rdata_s),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if ((halted_a && (rd_a || wr_a)) || (halted_s && (rd_s || wr_s))) leak_cnt++;
      if ((rd_a && wr_a) || (rd_s && wr_s)) both_cnt++;
      if (wr_a) wr_cnt_a++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  function automatic logic [15:0] ins(input int op, input int s);
    return 16'(((op & 15) << 12) | (s & 12'hFFF));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1;
    ld_addr = 12'(a);
    ld_data = d;
  endtask

  task automatic prep();
    for (int a = 0; a < 64; a++) put(a, ins(7, 0));
    for (int a = 'h100; a < 'h140; a++) put(a, 16'hDEAD);
  endtask

  task automatic run_prog(input string tag);
    int i;
    @(negedge clk);
    ld_en = 1'b0;
    rst_n = 1'b1;
    for (i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (halted_a && halted_s) break;
    end
    if (i >= 4000) chk({tag, " R8 halt reached"}, 0, 1);
    repeat (8) @(negedge clk);
    #1;
  endtask

  task automatic stop_prog();
    @(negedge clk);
    rst_n = 1'b0;
  endtask

  initial begin
    int leak0, wr0;
    logic [15:0] av [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
    logic [15:0] bv [8] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF,
                            16'h8000, 16'h0002, 16'hFFFE, 16'h4000};

    repeat (3) @(negedge clk);
    // R1: state while reset is held
    chk("R1 halted low in reset", {31'd0, halted_a}, 0);
    chk("R1 no write in reset", {31'd0, wr_a}, 0);
    chk("R1 fetch address 0", {20'd0, addr_a}, 0);

    // R3 R4 R8 R11: arithmetic sweep
    foreach (av[i]) begin
      foreach (av[j]) begin
        logic [15:0] a, b;
        a = av[i];
        b = av[j];
        prep();
        put(0, ins(0, 'h100));
        put(1, ins(2, 'h101));
        put(2, ins(1, 'h110));
        put(3, ins(1, 'h112));
        put(4, ins(0, 'h100));
        put(5, ins(3, 'h101));
        put(6, ins(1, 'h111));
        put(7, ins(7, 'hABC));
        put('h100, a);
        put('h101, b);
        leak0 = leak_cnt;
        wr0 = wr_cnt_a;
        run_prog("arith");
        chk("R4 add", {16'd0, u_mem_a.mem['h110]}, {16'd0, 16'(a + b)});
        chk("R4 sub", {16'd0, u_mem_a.mem['h111]}, {16'd0, 16'(a - b)});
        chk("R3 acc kept after store", {16'd0, u_mem_a.mem['h112]}, {16'd0, 16'(a + b)});
        chk("R3 one strobe per store", wr_cnt_a - wr0, 3);
        chk("R8 halted after stop", {31'd0, halted_a}, 1);
        chk("R8 no access after stop", leak_cnt - leak0, 0);
        stop_prog();
      end
    end

    // R5 R6 R7 R10: branch sweep
    foreach (bv[k]) begin
      logic [15:0] v;
      v = bv[k];
      prep();
      put(0, ins(0, 'h100));
      put(1, ins(5, 5));
      put(2, ins(0, 'h101));
      put(3, ins(1, 'h110));
      put(4, ins(4, 7));
      put(5, ins(0, 'h102));
      put(6, ins(1, 'h110));
      put(7, ins(0, 'h100));
      put(8, ins(6, 12));
      put(9, ins(0, 'h101));
      put(10, ins(1, 'h111));
      put(11, ins(7, 0));
      put(12, ins(0, 'h102));
      put(13, ins(1, 'h111));
      put(14, ins(7, 0));
      put('h100, v);
      put('h101, 16'h0000);
      put('h102, 16'h0001);
      run_prog("branch");
      chk("R6 R5 nonneg jump", {16'd0, u_mem_a.mem['h110]}, {31'd0, !v[15]});
      chk("R7 nonzero jump", {16'd0, u_mem_a.mem['h111]}, {31'd0, v != 0});
      chk("R10 strict positive jump", {16'd0, u_mem_s.mem['h110]}, {31'd0, !v[15] && v != 0});
      stop_prog();
    end

    // R9: unassigned opcodes
    for (int op = 8; op < 16; op++) begin
      prep();
      put(0, ins(0, 'h100));
      put(1, ins(op, 'h120));
      put(2, ins(1, 'h121));
      put(3, ins(7, 0));
      put('h100, 16'h1234);
      leak0 = leak_cnt;
      wr0 = wr_cnt_a;
      run_prog("unassigned");
      chk("R9 halted", {31'd0, halted_a}, 1);
      chk("R9 no write", wr_cnt_a - wr0, 0);
      chk("R9 operand untouched", {16'd0, u_mem_a.mem['h120]}, 32'hDEAD);
      chk("R9 following store skipped", {16'd0, u_mem_a.mem['h121]}, 32'hDEAD);
      chk("R9 quiet after halt", leak_cnt - leak0, 0);
      stop_prog();
    end

    // R4 R5 R7: multiply by repeated addition
    for (int ai = 0; ai < 2; ai++) begin
      for (int bi = 0; bi < 4; bi++) begin
        int a, b;
        a = (ai == 0) ? 3 : 'h1234;
        b = (bi == 0) ? 0 : (bi == 1) ? 1 : (bi == 2) ? 5 : 9;
        prep();
        put(0, ins(0, 'h104));
        put(1, ins(1, 'h102));
        put(2, ins(0, 'h101));
        put(3, ins(6, 5));
        put(4, ins(7, 0));
        put(5, ins(3, 'h103));
        put(6, ins(1, 'h101));
        put(7, ins(0, 'h102));
        put(8, ins(2, 'h100));
        put(9, ins(1, 'h102));
        put(10, ins(4, 2));
        put('h100, 16'(a));
        put('h101, 16'(b));
        put('h103, 16'h0001);
        put('h104, 16'h0000);
        run_prog("multiply");
        chk("R4 R5 multiply product", {16'd0, u_mem_a.mem['h102]}, {16'd0, 16'(a * b)});
        chk("R10 strict core same product", {16'd0, u_mem_s.mem['h102]}, {16'd0, 16'(a * b)});
        stop_prog();
      end
    end

    // R1 R2: reset ACC zero, PC wrap from 4095
    prep();
    put(0, ins(6, 3));
    put(1, ins(0, 'h100));
    put(2, ins(4, 4095));
    put(3, ins(7, 0));
    put(4095, ins(1, 'h110));
    put('h100, 16'h5A5A);
    wr0 = wr_cnt_a;
    run_prog("wrap");
    chk("R2 wrap store", {16'd0, u_mem_a.mem['h110]}, 32'h5A5A);
    chk("R1 R2 single pass", wr_cnt_a - wr0, 1);
    chk("R8 halted after wrap", {31'd0, halted_a}, 1);
    stop_prog();

    chk("R11 strobes exclusive", both_cnt, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule